// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events on an asynchronous pin against a free-running timer count. The pin is brought into the clock domain by a flop chain. It can then pass through an optional digital filter that moves its output only after a run of identical samples. A transition of the chosen polarity on the resulting level copies the timer count, supplied on an input port, into a capture register. The same event sets a capture flag, which drives an interrupt request when interrupts are enabled.

When the timer borrows the capture register as its TOP value, the pin is ignored. In that mode the register is instead written directly through a load port. The flag is cleared by a one-cycle clear strobe. The counter, waveform generation and bus decoding all sit outside this block.

Top module: `icap_unit`

## Requirements
- R1: After reset `cap_val` is 0, `cap_flag` is 0 and `irq` is 0. The filter history, the filtered level and the previous-level register also reset to 0.
- R2: With `filt_en`=0, a selected-polarity change of `cap_pin` made before clock edge k is captured at edge k+2. The stored value is the `cnt_val` present just before edge k+2. The delay is the two synchronizer stages plus one edge-detect register.
- R3: `edge_rise`=1 selects rising transitions (0 to 1) and `edge_rise`=0 selects falling transitions (1 to 0). A transition of the other polarity leaves `cap_val` and `cap_flag` unchanged.
- R4: With `filt_en`=1, the filtered level follows the synchronized pin only when the current sample and the three before it are all equal. A pulse shorter than four cycles causes no capture, and a pulse of exactly four cycles causes one capture.
- R5: With `filt_en`=1, a capture lands exactly four clock edges later than it would with `filt_en`=0, and it stores the `cnt_val` of that later cycle.
- R6: A capture event loads `cnt_val` into `cap_val` and sets `cap_flag` on the same clock edge.
- R7: `irq` is 1 exactly when `cap_flag`=1 and `irq_en`=1.
- R8: `flag_clr`=1 clears `cap_flag` on the next edge. If a capture occurs on that same edge, the flag stays set.
- R9: While `top_mode`=1, transitions on `cap_pin` cause no capture and do not set the flag.
- R10: While `top_mode`=1, `load_en`=1 writes `load_val` into `cap_val` on the next edge. With `top_mode`=0, `load_en` has no effect.
- R11: A level held steady after a transition produces exactly one capture, not one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| cnt_val | input | CNT_W | Current timer count |
| filt_en | input | 1 | 1 routes the pin through the four-sample filter |
| edge_rise | input | 1 | 1 = rising edge triggers, 0 = falling edge triggers |
| irq_en | input | 1 | Interrupt enable |
| top_mode | input | 1 | 1 = capture register serves as timer TOP, capture disabled |
| load_en | input | 1 | Direct write strobe for the capture register (top_mode only) |
| load_val | input | CNT_W | Value written by load_en |
| flag_clr | input | 1 | Write-one strobe that clears the capture flag |
| cap_val | output | CNT_W | Capture register |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a two-flop synchronizer and a four-sample filter. These values fix the latencies the scoreboard predicts, three edges unfiltered and seven filtered, so each capture is checked for both the exact cycle and the exact count value. A four-sample filter also makes the boundary cheap to reach: a three-cycle pulse must vanish, and a four-cycle pulse must produce exactly one capture.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int CNT_W_DEF    = 16;
    localparam int SYNC_DEF     = 2;
    localparam int FILT_LEN_DEF = 4;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = STAGES'({sync_q, pin_async});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_sync = sync_q[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    output logic lvl
);

    localparam int HW = LEN - 1;

    typedef struct packed {
        logic [HW-1:0] hist;
        logic          lvl;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [LEN-1:0] window;
    logic           all_one;
    logic           all_zero;

    always_comb begin
        window   = {st_q.hist, smp};
        all_one  = &window;
        all_zero = ~|window;
        st_d      = st_q;
        st_d.hist = HW'(window);
        if (all_one || all_zero) begin
            st_d.lvl = smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl = st_q.lvl;

endmodule

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_raw,
    input  logic lvl_filt,
    input  logic filt_en,
    input  logic edge_rise,
    input  logic block,
    output logic evt
);

    logic prev_d, prev_q;
    logic lvl_sel;
    logic went_up;
    logic went_down;

    always_comb begin
        lvl_sel   = filt_en ? lvl_filt : lvl_raw;
        went_up   = lvl_sel & ~prev_q;
        went_down = ~lvl_sel & prev_q;
        prev_d    = lvl_sel;
        if (block) begin
            evt = 1'b0;
        end else if (edge_sel_e'(edge_rise) == EDGE_RISE) begin
            evt = went_up;
        end else begin
            evt = went_down;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    parameter int FILT_LEN    = FILT_LEN_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             irq_en,
    input  logic             top_mode,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    pin_s;
    logic    pin_f;
    logic    cap_evt;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(cap_pin),
        .pin_sync (pin_s)
    );

    icap_filter #(.LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .smp  (pin_s),
        .lvl  (pin_f)
    );

    icap_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_raw  (pin_s),
        .lvl_filt (pin_f),
        .filt_en  (filt_en),
        .edge_rise(edge_rise),
        .block    (top_mode),
        .evt      (cap_evt)
    );

    always_comb begin
        st_d = st_q;
        if (cap_evt) begin
            st_d.cap = cnt_val;
        end else if (top_mode && load_en) begin
            st_d.cap = load_val;
        end
        if (cap_evt) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_val  = st_q.cap;
    assign cap_flag = st_q.flag;
    assign irq      = st_q.flag & irq_en;

endmodule

// File: rtl/icap_checker.sv
module icap_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             top_mode,
    input logic             load_en,
    input logic [CNT_W-1:0] load_val,
    input logic             flag_clr,
    input logic             cap_evt,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cap_val == '0) && !cap_flag);

    assert_capture_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag && (cap_val == $past(cnt_val)));

    assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_evt) |=> !cap_flag);

    assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && cap_evt) |=> cap_flag);

    assert_top_no_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        top_mode |-> !cap_evt);

    assert_top_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && !load_en) |=> $stable(cap_val));

    assert_load_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && load_en) |=> (cap_val == $past(load_val)));

    assert_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_mode && !cap_evt) |=> $stable(cap_val));

    assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> !cap_evt);

endmodule

bind icap_unit icap_checker #(.CNT_W(CNT_W)) u_icap_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_val (cnt_val),
    .top_mode(top_mode),
    .load_en (load_en),
    .load_val(load_val),
    .flag_clr(flag_clr),
    .cap_evt (cap_evt),
    .cap_val (cap_val),
    .cap_flag(cap_flag)
);

// File: tb/icap_unit_bench.sv
`timescale 1ns/1ps
module icap_unit_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_pin = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         filt_en = 1'b0;
    logic         edge_rise = 1'b1;
    logic         irq_en = 1'b0;
    logic         top_mode = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] cap_val;
    logic         cap_flag;
    logic         irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [W-1:0] base = 16'h0100;
    logic [W-1:0] last_cap = '0;
    bit run_done = 1'b0;
    bit mon_on = 1'b0;

    typedef struct {
        logic [W-1:0] val;
        int           at;
        string        tag;
    } exp_t;
    exp_t sb[$];

    icap_unit u_icap_unit (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cnt_val(cnt_val),
        .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en),
        .top_mode(top_mode), .load_en(load_en), .load_val(load_val),
        .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every change of the capture register must match the head of the scoreboard.
    always @(negedge clk) begin
        if (mon_on && cap_val != last_cap) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3/R9/R11 unexpected capture", int'(cap_val), int'(last_cap));
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cap_val == e.val, {e.tag, " value"}, int'(cap_val), int'(e.val));
                check(cyc == e.at, {e.tag, " cycle"}, cyc, e.at);
            end
            last_cap = cap_val;
        end
    end

    // Drive a pin level; count advances every cycle. exp: push expected capture.
    task automatic drive_pin(input logic v, input bit exp, input bit clr_at_cap, input string tag);
        int lat;
        int c;
        exp_t e;
        lat = filt_en ? 6 : 2;
        @(negedge clk);
        base = base + 16'h0100;
        cap_pin = v;
        cnt_val = base;
        c = cyc;
        if (exp) begin
            e.val = base + W'(lat);
            e.at  = c + lat + 1;
            e.tag = tag;
            sb.push_back(e);
        end
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            cnt_val = base + W'(i);
            flag_clr = clr_at_cap && (i == lat);
        end
        flag_clr = 1'b0;
    endtask

    // High pulse of len cycles from a low level, filter assumed on.
    task automatic pulse(input int len, input bit exp, input string tag);
        int c;
        exp_t e;
        @(negedge clk);
        base = base + 16'h0100;
        cap_pin = 1'b1;
        cnt_val = base;
        c = cyc;
        if (exp) begin
            e.val = base + W'(6);
            e.at  = c + 7;
            e.tag = tag;
            sb.push_back(e);
        end
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            cnt_val = base + W'(i);
            if (i == len) cap_pin = 1'b0;
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        check(cap_val == '0, "R1 cap_val reset", int'(cap_val), 0);
        check(cap_flag == 1'b0, "R1 flag reset", int'(cap_flag), 0);
        check(irq == 1'b0, "R1 irq reset", int'(irq), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);

        // Unfiltered rising capture
        irq_en = 1'b1;
        drive_pin(1'b1, 1'b1, 1'b0, "R2/R6 unfiltered rise");
        check(cap_flag == 1'b1, "R6 flag set", int'(cap_flag), 1);
        check(irq == 1'b1, "R7 irq with enable", int'(irq), 1);
        @(negedge clk) irq_en = 1'b0;
        #1 check(irq == 1'b0, "R7 irq masked", int'(irq), 0);
        irq_en = 1'b1;

        // Held level: no more captures
        repeat (12) @(negedge clk);
        check(sb.size() == 0, "R11 single capture", sb.size(), 0);
        clear_flag();
        check(cap_flag == 1'b0, "R8 flag cleared", int'(cap_flag), 0);
        check(irq == 1'b0, "R7 irq follows flag", int'(irq), 0);

        // Falling edge ignored when rising selected
        held = cap_val;
        drive_pin(1'b0, 1'b0, 1'b0, "R3");
        check(cap_flag == 1'b0, "R3 falling ignored flag", int'(cap_flag), 0);
        check(cap_val == held, "R3 falling ignored value", int'(cap_val), int'(held));

        // Falling edge selected
        edge_rise = 1'b0;
        drive_pin(1'b1, 1'b0, 1'b0, "R3");
        check(cap_flag == 1'b0, "R3 rising ignored flag", int'(cap_flag), 0);
        drive_pin(1'b0, 1'b1, 1'b0, "R3 falling capture");
        check(cap_flag == 1'b1, "R3 falling sets flag", int'(cap_flag), 1);

        // Clear coinciding with capture
        drive_pin(1'b1, 1'b0, 1'b0, "R3");
        drive_pin(1'b0, 1'b1, 1'b1, "R8 collision capture");
        check(cap_flag == 1'b1, "R8 capture beats clear", int'(cap_flag), 1);

        // Filtered path
        clear_flag();
        edge_rise = 1'b1;
        filt_en = 1'b1;
        repeat (4) @(negedge clk);
        drive_pin(1'b1, 1'b1, 1'b0, "R5 filtered rise");
        drive_pin(1'b0, 1'b0, 1'b0, "R4");
        clear_flag();
        held = cap_val;
        pulse(3, 1'b0, "R4");
        check(cap_flag == 1'b0, "R4 short pulse rejected", int'(cap_flag), 0);
        check(cap_val == held, "R4 short pulse value", int'(cap_val), int'(held));
        pulse(4, 1'b1, "R4 four-cycle pulse");
        check(cap_flag == 1'b1, "R4 four-cycle pulse flag", int'(cap_flag), 1);

        // TOP mode
        filt_en = 1'b0;
        repeat (4) @(negedge clk);
        clear_flag();
        top_mode = 1'b1;
        held = cap_val;
        drive_pin(1'b1, 1'b0, 1'b0, "R9");
        check(cap_flag == 1'b0, "R9 no flag in top mode", int'(cap_flag), 0);
        check(cap_val == held, "R9 no capture in top mode", int'(cap_val), int'(held));
        begin
            exp_t e;
            @(negedge clk);
            load_en = 1'b1;
            load_val = 16'hBEEF;
            e.val = 16'hBEEF;
            e.at = cyc + 1;
            e.tag = "R10 load in top mode";
            sb.push_back(e);
            @(negedge clk);
            load_en = 1'b0;
        end
        repeat (2) @(negedge clk);
        check(cap_val == 16'hBEEF, "R10 loaded value", int'(cap_val), 16'hBEEF);
        top_mode = 1'b0;
        @(negedge clk);
        load_en = 1'b1;
        load_val = 16'h1234;
        @(negedge clk);
        load_en = 1'b0;
        repeat (2) @(negedge clk);
        check(cap_val == 16'hBEEF, "R10 load ignored outside top mode", int'(cap_val), 16'hBEEF);

        // Unfiltered capture after leaving TOP mode
        drive_pin(1'b0, 1'b0, 1'b0, "R3");
        drive_pin(1'b1, 1'b1, 1'b0, "R2 capture after top mode");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
        run_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule